// File: doc/BRIEF.md
# Self-Timed Pulse Stretcher

This block widens a short input pulse of any width into an output pulse whose length is set by a clocked delay. A high level on the input sets a set/reset latch, and the stretched output follows it at once, with no register in the path. The latch state feeds a delay stage that moves forward only on cycles where the delay tick enable is high. When the delayed copy goes high it clears the latch and is also driven out as a second, delayed pulse.

The delay stage works in one of two modes. The short mode is a two-tick synchronizer. The long mode is a four-tick filter: its output changes only after four tick samples in a row agree. The block can accept a new pulse only after the delayed copy has gone low again. If the input is still high while the clearing signal is active, a policy input decides the outcome: force the output low, force it high, or keep the previous value. The clearing path is level-sensitive, so a clear that is missed simply arrives again and the block cannot get stuck.

Top module: `pulse_stretch`

## Requirements
- R1: When `pulse_in` is high and `delayed_out` is low, `stretch_out` is high in the same cycle, with no clock delay.
- R2: When `pulse_in` and `delayed_out` are both low, `stretch_out` keeps the value it had in the previous cycle.
- R3: When `delayed_out` is high and `pulse_in` is low, `stretch_out` is low.
- R4: With `conflict_sel` = 2'b00 (force low), `pulse_in` and `delayed_out` both high give a low `stretch_out`.
- R5: With `conflict_sel` = 2'b01 (force high), `pulse_in` and `delayed_out` both high give a high `stretch_out`. An input held high through the whole clear window produces one long pulse and no second rising edge.
- R6: With `conflict_sel` = 2'b10 or 2'b11 (hold), `pulse_in` and `delayed_out` both high leave `stretch_out` at its previous value.
- R7: With `long_mode` = 0, `delayed_out` is the latch level sampled two ticks earlier. With one tick per cycle, a single-cycle input gives a `stretch_out` pulse 2 cycles wide and a `delayed_out` pulse 2 cycles wide.
- R8: With `long_mode` = 1, `delayed_out` changes only after four consecutive ticks sample the same latch level. With one tick per cycle, a single-cycle input gives `stretch_out` and `delayed_out` pulses 4 cycles wide each.
- R9: The delay stage advances only on cycles where `tick_en` is high. If `tick_en` is low and `long_mode` does not change, `delayed_out` holds in the next cycle.
- R10: While `rst_n` is low, `stretch_out` is low. A clock edge with `rst_n` low clears the latch and the whole delay pipeline.
- R11: With force-low, an input that is still high after the clear begins produces a second pulse once `delayed_out` has returned low. Holding the input high for 8 cycles at one tick per cycle in short mode gives exactly two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Set input of the latch, level-sensitive |
| tick_en | input | 1 | Enable that advances the delay stage |
| long_mode | input | 1 | 0: two-tick synchronizer, 1: four-tick filter |
| conflict_sel | input | 2 | Policy when set and clear are both active: 00 low, 01 high, 1x hold |
| stretch_out | output | 1 | Stretched pulse, follows the latch with no clock delay |
| delayed_out | output | 1 | Delayed copy of the latch, also clears the latch |

## Verification
The assertions check on every cycle how the latch resolves each combination of set and clear (R1 to R6). They also check that the delayed output is frozen in cycles without a tick (R9) and that reset clears both outputs (R10). Pulse widths, the two-tick and four-tick delays and the recovery sequence span many cycles and depend on tick history. Only the bench's scenarios show these (R7, R8, R11, and the long pulse in R5), by comparing against a behavioural model of the sample history on every clock and by counting widths and rising edges.

// File: rtl/pstr_pkg.sv
// Package: shared types for the pulse stretcher.
// Assumes: the policy code is 2 bits wide; codes 2 and 3 both mean hold.
package pstr_pkg;
    typedef enum logic [1:0] {
        POL_LOW  = 2'b00,
        POL_HIGH = 2'b01,
        POL_HOLD = 2'b10,
        POL_HLD2 = 2'b11
    } conflict_pol_e;

    localparam int SYNC_TICKS = 2;
    localparam int FILT_TICKS = 4;
endpackage

// File: rtl/pstr_latch.sv
// Module: pstr_latch
// A set/reset latch modelled as a state register with a combinational
// resolve. The output follows set at once; the register keeps the level
// for the following cycles.
// Assumes: set_i and clr_i are synchronous to clk; reset is active low.
module pstr_latch
    import pstr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  conflict_pol_e pol_i,
    output logic          level_o
);
    logic state_q;
    logic resolved;

    // Resolve set, clear and the conflict policy into the next level.
    always_comb begin
        unique case ({set_i, clr_i})
            2'b10:   resolved = 1'b1;
            2'b01:   resolved = 1'b0;
            2'b00:   resolved = state_q;
            default: begin
                unique case (pol_i)
                    POL_LOW:  resolved = 1'b0;
                    POL_HIGH: resolved = 1'b1;
                    default:  resolved = state_q;
                endcase
            end
        endcase
    end

    // Output is forced low while reset is asserted.
    assign level_o = rst_n & resolved;

    // Store the resolved level for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= 1'b0;
        else        state_q <= resolved;
    end
endmodule

// File: rtl/pstr_delay.sv
// Module: pstr_delay
// Delays a level by a tick count chosen at run time: a short synchronizer
// that takes SYNC_N taps, or a filter that changes state only after FILT_N
// agreeing samples. The stage advances only when tick_i is high.
// Assumes: FILT_N >= SYNC_N >= 1 and FILT_N >= 2.
module pstr_delay #(
    parameter int SYNC_N = pstr_pkg::SYNC_TICKS,
    parameter int FILT_N = pstr_pkg::FILT_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic mode_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int DEPTH = (SYNC_N > FILT_N) ? SYNC_N : FILT_N;

    logic [DEPTH-1:0]  taps_q;
    logic [FILT_N-1:0] window;
    logic              filt_q;

    // Window of the newest FILT_N samples, the incoming one included.
    assign window = {taps_q[FILT_N-2:0], din_i};

    // Shift register of samples; tap 0 holds the newest one.
    always_ff @(posedge clk) begin
        if (!rst_n)      taps_q <= '0;
        else if (tick_i) taps_q <= {taps_q[DEPTH-2:0], din_i};
    end

    // Filter state: changes only when the whole window agrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
        end else if (tick_i) begin
            if (&window)       filt_q <= 1'b1;
            else if (~|window) filt_q <= 1'b0;
        end
    end

    // Pick the variant selected by the mode.
    assign dout_o = mode_i ? filt_q : taps_q[SYNC_N-1];

    // R9: with no tick and a steady mode, the output is frozen.
    assert_no_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && rst_n) |=> ((mode_i != $past(mode_i)) || $stable(dout_o)));
endmodule

// File: rtl/pulse_stretch.sv
// Module: pulse_stretch (top)
// Pulse stretcher: the input sets a latch, the latch level passes through a
// tick-driven delay, and the delayed level clears the latch and is also
// driven out. Clearing is level-sensitive, so a missed clear cannot stall it.
// Assumes: all inputs are synchronous to clk; rst_n is synchronous, active low.
module pulse_stretch #(
    parameter int SYNC_N = pstr_pkg::SYNC_TICKS,
    parameter int FILT_N = pstr_pkg::FILT_TICKS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pulse_in,
    input  logic       tick_en,
    input  logic       long_mode,
    input  logic [1:0] conflict_sel,
    output logic       stretch_out,
    output logic       delayed_out
);
    import pstr_pkg::*;

    conflict_pol_e pol;
    logic          level;
    logic          delayed;

    // Map the plain port to the policy type.
    assign pol = conflict_pol_e'(conflict_sel);

    pstr_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pulse_in),
        .clr_i  (delayed),
        .pol_i  (pol),
        .level_o(level)
    );

    pstr_delay #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_en),
        .mode_i(long_mode),
        .din_i (level),
        .dout_o(delayed)
    );

    assign stretch_out = level;
    assign delayed_out = delayed;

    // R1: set without clear shows at the output in the same cycle.
    assert_set_now_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_in && !delayed_out) |-> stretch_out);

    // R2: with neither set nor clear, the output keeps its last value.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pulse_in || delayed_out) || (stretch_out == $past(stretch_out))));

    // R3: clear alone forces the output low.
    assert_clear_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (delayed_out && !pulse_in) |-> !stretch_out);

    // R4: force-low policy on conflict.
    assert_pol_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (delayed_out && pulse_in && conflict_sel == 2'b00) |-> !stretch_out);

    // R5: force-high policy on conflict.
    assert_pol_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (delayed_out && pulse_in && conflict_sel == 2'b01) |-> stretch_out);

    // R6: hold policy on conflict keeps the previous output.
    assert_pol_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (!(delayed_out && pulse_in && conflict_sel[1])
                   || (stretch_out == $past(stretch_out))));

    // R10: an edge in reset leaves both outputs low.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!delayed_out && (rst_n || !stretch_out)));
endmodule

// File: tb/sim_pulse_stretch.sv
module sim_pulse_stretch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_in = 1'b0;
    logic       tick_en = 1'b0;
    logic       long_mode = 1'b0;
    logic [1:0] conflict_sel = 2'b00;
    logic       stretch_out;
    logic       delayed_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Scenario globals, applied inside cyc at the falling edge.
    logic       g_mode = 1'b0;
    logic [1:0] g_pol = 2'b00;
    string      cur_req = "R10";

    // Reference model state.
    logic mq;
    logic mf;
    logic ms[4];
    int   hi_cnt, dhi_cnt, rises;
    logic prev_s;

    always #5 clk = ~clk;

    pulse_stretch u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .tick_en(tick_en),
        .long_mode(long_mode), .conflict_sel(conflict_sel),
        .stretch_out(stretch_out), .delayed_out(delayed_out)
    );

    function automatic logic resolve(logic p, logic r, logic q, logic [1:0] pol);
        if (p && !r) return 1'b1;
        if (!p && r) return 1'b0;
        if (!p && !r) return q;
        if (pol == 2'b00) return 1'b0;
        if (pol == 2'b01) return 1'b1;
        return q;
    endfunction

    function automatic logic model_delayed(logic mode);
        return mode ? mf : ms[1];
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        mq = 0; mf = 0;
        foreach (ms[i]) ms[i] = 0;
    endtask

    task automatic clear_counts();
        hi_cnt = 0; dhi_cnt = 0; rises = 0; prev_s = stretch_out;
    endtask

    // One clock: drive inputs, compare with the model, then advance the model.
    task automatic cyc(logic p, logic t, logic r);
        logic ed, es, y;
        @(negedge clk);
        pulse_in = p; tick_en = t; rst_n = r;
        long_mode = g_mode; conflict_sel = g_pol;
        #1;
        ed = model_delayed(g_mode);
        y  = resolve(p, ed, mq, g_pol);
        es = r ? y : 1'b0;
        check(cur_req, delayed_out, ed, "delayed_out");
        check(cur_req, stretch_out, es, "stretch_out");
        if (stretch_out) hi_cnt++;
        if (delayed_out) dhi_cnt++;
        if (stretch_out && !prev_s) rises++;
        prev_s = stretch_out;
        if (!r) model_reset();
        else begin
            mq = y;
            if (t) begin
                if (y && ms[0] && ms[1] && ms[2]) mf = 1;
                else if (!y && !ms[0] && !ms[1] && !ms[2]) mf = 0;
                for (int i = 3; i > 0; i--) ms[i] = ms[i-1];
                ms[0] = y;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        // R10: reset with input high keeps both outputs low.
        cur_req = "R10";
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b0);
        check("R10", stretch_out, 0, "reset stretch_out");
        check("R10", delayed_out, 0, "reset delayed_out");
        idle(3);

        // R1 R3 R7: short mode, one-cycle input.
        cur_req = "R7"; g_mode = 0; g_pol = 2'b00;
        idle(1); clear_counts();
        cyc(1'b1, 1'b1, 1'b1);
        check("R1", stretch_out, 1, "immediate set");
        idle(9);
        check("R7", hi_cnt, 2, "stretch width sync");
        check("R7", dhi_cnt, 2, "delayed width sync");
        check("R3", stretch_out, 0, "cleared after pulse");

        // R8: long mode, one-cycle input.
        cur_req = "R8"; g_mode = 1;
        idle(6); clear_counts();
        cyc(1'b1, 1'b1, 1'b1);
        idle(14);
        check("R8", hi_cnt, 4, "stretch width filter");
        check("R8", dhi_cnt, 4, "delayed width filter");

        // R9: sparse ticks in both modes.
        cur_req = "R9";
        for (int m = 0; m < 2; m++) begin
            g_mode = m[0];
            idle(6);
            cyc(1'b1, 1'b0, 1'b1);
            for (int i = 0; i < 30; i++) cyc(1'b0, (i % 3) == 0, 1'b1);
        end

        // R5: force high, input held through the clear window.
        cur_req = "R5"; g_mode = 0; g_pol = 2'b01;
        idle(8); clear_counts();
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b1);
        idle(8);
        check("R5", rises, 1, "rising edges force-high");
        check("R5", hi_cnt, 8, "long pulse width");

        // R4 R11: force low, input held past the clear start.
        cur_req = "R11"; g_pol = 2'b00;
        idle(8); clear_counts();
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b1);
        idle(8);
        check("R11", rises, 2, "rising edges force-low");

        // R6: hold policy behaves like force high on a held input.
        cur_req = "R6"; g_pol = 2'b10;
        idle(8); clear_counts();
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 1'b1);
        idle(8);
        check("R6", rises, 1, "rising edges hold");

        // R10: reset in the middle of a pulse.
        cur_req = "R10"; g_mode = 1; g_pol = 2'b00;
        idle(8);
        cyc(1'b1, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b1, 1'b1);
        check("R10", stretch_out, 0, "latch cleared by reset");
        check("R10", delayed_out, 0, "pipeline cleared by reset");

        // R2: mixed random stimulus over every mode and policy.
        cur_req = "R2"; lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if ((i % 200) == 0) begin g_mode = lfsr[3]; g_pol = lfsr[5:4]; end
            cyc(lfsr[0] & lfsr[1] & lfsr[2], lfsr[7] | lfsr[8], (i % 997) != 500);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule